// File: doc/BRIEF.md
# MMU Control Register Access Unit

This unit holds the control registers a processor uses to manage its memory-management unit and decides, for every special-register read or write, whether that access is permitted. The permission rules come from two elaboration-time parameters: the MMU mode and the TLB access level. Accesses to the TLB data words are indirect. The index register selects one entry of a pair of TLB arrays (low word and high word) and of a companion tag-ID array.

A write that changes the process identifier or the zone protection word raises a one-cycle flush pulse, which tells cached translations to be discarded. A write to the search register sends a lookup request to an external translation engine. That engine later answers with hit/miss and an entry number, and the answer lands in the index register.

All results are registered. Read data, the refusal strobe, the flush pulse and the lookup request appear one clock after the access cycle.

Top module: `mmu_sreg_ctrl`

## Requirements
- R1: With MMU mode below 2 or an access level of 0, every access is refused. A refused read returns zero. A refused write changes no register and produces neither a flush pulse nor a lookup request.
- R2: Reads of the TLB low word (register 4) and TLB high word (register 5) are refused, returning zero, unless bit 0 of the access level is set.
- R3: Reads of the process-ID register (register 0) and the zone register (register 1) are refused, returning zero, unless bit 0 of the access level is set.
- R4: Writes to the process-ID, zone and search (register 3) registers are refused when the access level is 1 or lower. All other registers, including the index register (register 2), accept writes whenever R1 does not apply.
- R5: Registers 4 and 5 address the TLB entry given by the low index bits of register 2. The LSB of the register number picks the high (1) or low (0) array. A write to register 5 also stores the low 8 bits of the process ID as that entry's tag ID.
- R6: A permitted read of register 5 loads the entry's stored tag ID, zero-extended, into the process-ID register.
- R7: A permitted write to register 0 or 1 that changes its value raises flush_pulse for one cycle after the access. Writing the value already held raises nothing.
- R8: A permitted write to register 3 raises lookup_req for one cycle after the access. lookup_vaddr carries the written value with its low 10 bits cleared, and lookup_user carries user_mode.
- R9: Reset clears all eight control registers and every output to zero. It leaves the TLB array contents unchanged.
- R10: When lookup_done is high, a hit loads lookup_entry, zero-extended, into the index register. A miss loads 0x8000_0000 (only the MSB set).
- R11: Every refused access raises err_strobe for exactly one cycle after the access. Every read, permitted or refused, raises rd_valid for one cycle with its data on rd_data. Otherwise rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 3 | Register number (0 PID, 1 zone, 2 index, 3 search, 4 TLB low, 5 TLB high, 6/7 spare) |
| acc_wdata | input | 32 | Write data |
| user_mode | input | 1 | Current privilege (1 = user), sent with searches |
| lookup_done | input | 1 | Translation engine answers this cycle |
| lookup_hit | input | 1 | Answer is a hit |
| lookup_entry | input | 8 | Matching entry number |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| err_strobe | output | 1 | Previous access was refused |
| flush_pulse | output | 1 | Cached translations must be dropped |
| lookup_req | output | 1 | Search request |
| lookup_vaddr | output | 32 | Masked search address |
| lookup_user | output | 1 | Privilege sent with the search |

## Verification
Every direct result (read data, rd_valid, err_strobe, flush_pulse and the lookup request fields) is due at the first clock edge after the access cycle. The bench's reference model advances at each rising edge, and the bench compares all outputs at the falling edge that follows.

Indirect effects take one more access to become visible at the ports. These are the tag-ID copy into the process ID, the index update from a lookup answer, and RAM retention across reset. The stimulus therefore follows each of them with a read and checks that read one edge later.

Four instances with different mode/level settings receive the same stimulus, so each gating rule is exercised against a configuration that permits it and one that refuses it.

// File: rtl/mmu_sreg_pkg.sv
package mmu_sreg_pkg;

    typedef enum logic [2:0] {
        SR_PID    = 3'd0,
        SR_ZONE   = 3'd1,
        SR_INDEX  = 3'd2,
        SR_SEARCH = 3'd3,
        SR_TLB_LO = 3'd4,
        SR_TLB_HI = 3'd5,
        SR_SPARE6 = 3'd6,
        SR_SPARE7 = 3'd7
    } sreg_e;

    localparam int unsigned NUM_SREGS = 8;

endpackage

// File: rtl/mmu_sreg_gate.sv
module mmu_sreg_gate
    import mmu_sreg_pkg::*;
#(
    parameter int unsigned MMU_MODE   = 3,
    parameter int unsigned TLB_ACCESS = 3
) (
    input  logic  acc_valid,
    input  logic  acc_write,
    input  sreg_e acc_sel,
    output logic  grant,
    output logic  refuse
);
    localparam bit BASE_OK = (MMU_MODE >= 2) && (TLB_ACCESS != 0);
    localparam bit RD_PRIV = (TLB_ACCESS % 2) == 1;
    localparam bit WR_PRIV = TLB_ACCESS > 1;

    logic permitted;

    always_comb begin
        permitted = BASE_OK;
        if (acc_write) begin
            if (acc_sel inside {SR_PID, SR_ZONE, SR_SEARCH}) begin
                permitted = BASE_OK && WR_PRIV;
            end
        end else begin
            if (acc_sel inside {SR_PID, SR_ZONE, SR_TLB_LO, SR_TLB_HI}) begin
                permitted = BASE_OK && RD_PRIV;
            end
        end
        grant  = acc_valid && permitted;
        refuse = acc_valid && !permitted;
    end

endmodule

// File: rtl/mmu_tlb_array.sv
module mmu_tlb_array #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/mmu_sreg_ctrl.sv
module mmu_sreg_ctrl
    import mmu_sreg_pkg::*;
#(
    parameter int unsigned MMU_MODE   = 3,
    parameter int unsigned TLB_ACCESS = 3,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned TLB_DEPTH  = 256,
    parameter int unsigned TID_W      = 8,
    parameter int unsigned PAGE_BITS  = 10,
    localparam int unsigned IDX_W     = $clog2(TLB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [2:0]        acc_reg,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              user_mode,
    input  logic              lookup_done,
    input  logic              lookup_hit,
    input  logic [IDX_W-1:0]  lookup_entry,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_strobe,
    output logic              flush_pulse,
    output logic              lookup_req,
    output logic [DATA_W-1:0] lookup_vaddr,
    output logic              lookup_user
);
    localparam logic [DATA_W-1:0] EPN_MASK  = {{(DATA_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};
    localparam logic [DATA_W-1:0] NOT_FOUND = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [NUM_SREGS-1:0][DATA_W-1:0] regs;
        logic                             rd_valid;
        logic [DATA_W-1:0]                rd_data;
        logic                             err;
        logic                             flush;
        logic                             lreq;
        logic [DATA_W-1:0]                lvaddr;
        logic                             luser;
    } state_t;

    state_t st_d, st_q;

    sreg_e             sel;
    logic              grant, refuse;
    logic [IDX_W-1:0]  tlb_idx;
    logic [1:0]        bank_we;
    logic [DATA_W-1:0] bank_rd [2];
    logic              tid_we;
    logic [TID_W-1:0]  tid_rd;

    assign sel     = sreg_e'(acc_reg);
    assign tlb_idx = st_q.regs[SR_INDEX][IDX_W-1:0];

    mmu_sreg_gate #(
        .MMU_MODE  (MMU_MODE),
        .TLB_ACCESS(TLB_ACCESS)
    ) gate_i (
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_sel  (sel),
        .grant    (grant),
        .refuse   (refuse)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        mmu_tlb_array #(
            .WIDTH(DATA_W),
            .DEPTH(TLB_DEPTH)
        ) bank_i (
            .clk  (clk),
            .we   (bank_we[b]),
            .addr (tlb_idx),
            .wdata(acc_wdata),
            .rdata(bank_rd[b])
        );
    end

    mmu_tlb_array #(
        .WIDTH(TID_W),
        .DEPTH(TLB_DEPTH)
    ) tid_i (
        .clk  (clk),
        .we   (tid_we),
        .addr (tlb_idx),
        .wdata(st_q.regs[SR_PID][TID_W-1:0]),
        .rdata(tid_rd)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.rd_data  = '0;
        st_d.err      = 1'b0;
        st_d.flush    = 1'b0;
        st_d.lreq     = 1'b0;
        bank_we       = 2'b00;
        tid_we        = 1'b0;

        if (refuse) begin
            st_d.err      = 1'b1;
            st_d.rd_valid = !acc_write;
        end

        if (grant && !acc_write) begin
            st_d.rd_valid = 1'b1;
            case (sel)
                SR_TLB_LO: st_d.rd_data = bank_rd[0];
                SR_TLB_HI: begin
                    st_d.rd_data      = bank_rd[1];
                    st_d.regs[SR_PID] = {{(DATA_W-TID_W){1'b0}}, tid_rd};
                end
                default:   st_d.rd_data = st_q.regs[sel];
            endcase
        end

        if (grant && acc_write) begin
            case (sel)
                SR_TLB_LO: bank_we[0] = 1'b1;
                SR_TLB_HI: begin
                    bank_we[1] = 1'b1;
                    tid_we     = 1'b1;
                end
                SR_PID, SR_ZONE: begin
                    st_d.flush     = acc_wdata != st_q.regs[sel];
                    st_d.regs[sel] = acc_wdata;
                end
                SR_SEARCH: begin
                    st_d.regs[sel] = acc_wdata & EPN_MASK;
                    st_d.lreq      = 1'b1;
                    st_d.lvaddr    = acc_wdata & EPN_MASK;
                    st_d.luser     = user_mode;
                end
                default:   st_d.regs[sel] = acc_wdata;
            endcase
        end

        if (lookup_done) begin
            st_d.regs[SR_INDEX] = lookup_hit ? {{(DATA_W-IDX_W){1'b0}}, lookup_entry} : NOT_FOUND;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid     = st_q.rd_valid;
    assign rd_data      = st_q.rd_data;
    assign err_strobe   = st_q.err;
    assign flush_pulse  = st_q.flush;
    assign lookup_req   = st_q.lreq;
    assign lookup_vaddr = st_q.lvaddr;
    assign lookup_user  = st_q.luser;

    AST_REFUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> !flush_pulse && !lookup_req); // R1

    AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && rd_valid) |-> rd_data == '0); // R2

    AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> (st_q.regs[SR_PID] != $past(st_q.regs[SR_PID]))
                     || (st_q.regs[SR_ZONE] != $past(st_q.regs[SR_ZONE]))); // R7

    AST_SEARCH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_req |-> (lookup_vaddr & ~EPN_MASK) == '0); // R8

    AST_ERR_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> $past(acc_valid)); // R11

endmodule

// File: tb/mmu_sreg_ctrl_tb.sv
module mmu_sreg_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NDUT       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [2:0]  acc_reg = '0;
    logic [31:0] acc_wdata = '0;
    logic        user_mode = 1'b0;
    logic        lookup_done = 1'b0, lookup_hit = 1'b0;
    logic [7:0]  lookup_entry = '0;

    logic        o_rdv [NDUT];
    logic [31:0] o_rd  [NDUT];
    logic        o_err [NDUT];
    logic        o_fl  [NDUT];
    logic        o_lr  [NDUT];
    logic [31:0] o_lva [NDUT];
    logic        o_lu  [NDUT];

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_sreg_ctrl dut_i (.clk, .rst_n, .acc_valid, .acc_write, .acc_reg, .acc_wdata,
        .user_mode, .lookup_done, .lookup_hit, .lookup_entry,
        .rd_valid(o_rdv[0]), .rd_data(o_rd[0]), .err_strobe(o_err[0]), .flush_pulse(o_fl[0]),
        .lookup_req(o_lr[0]), .lookup_vaddr(o_lva[0]), .lookup_user(o_lu[0]));
    mmu_sreg_ctrl #(.TLB_ACCESS(1)) dut_ro (.clk, .rst_n, .acc_valid, .acc_write, .acc_reg,
        .acc_wdata, .user_mode, .lookup_done, .lookup_hit, .lookup_entry,
        .rd_valid(o_rdv[1]), .rd_data(o_rd[1]), .err_strobe(o_err[1]), .flush_pulse(o_fl[1]),
        .lookup_req(o_lr[1]), .lookup_vaddr(o_lva[1]), .lookup_user(o_lu[1]));
    mmu_sreg_ctrl #(.TLB_ACCESS(2)) dut_wo (.clk, .rst_n, .acc_valid, .acc_write, .acc_reg,
        .acc_wdata, .user_mode, .lookup_done, .lookup_hit, .lookup_entry,
        .rd_valid(o_rdv[2]), .rd_data(o_rd[2]), .err_strobe(o_err[2]), .flush_pulse(o_fl[2]),
        .lookup_req(o_lr[2]), .lookup_vaddr(o_lva[2]), .lookup_user(o_lu[2]));
    mmu_sreg_ctrl #(.MMU_MODE(1)) dut_off (.clk, .rst_n, .acc_valid, .acc_write, .acc_reg,
        .acc_wdata, .user_mode, .lookup_done, .lookup_hit, .lookup_entry,
        .rd_valid(o_rdv[3]), .rd_data(o_rd[3]), .err_strobe(o_err[3]), .flush_pulse(o_fl[3]),
        .lookup_req(o_lr[3]), .lookup_vaddr(o_lva[3]), .lookup_user(o_lu[3]));

    // reference model state
    logic [31:0] m_reg [NDUT][8];
    logic [31:0] m_lo  [NDUT][256];
    logic [31:0] m_hi  [NDUT][256];
    logic [7:0]  m_tid [NDUT][256];
    logic        e_rdv [NDUT];
    logic [31:0] e_rd  [NDUT];
    logic        e_err [NDUT];
    logic        e_fl  [NDUT];
    logic        e_lr  [NDUT];
    logic [31:0] e_lva [NDUT];
    logic        e_lu  [NDUT];

    int    errors = 0, checks = 0;
    bit    finished = 0;
    string phase = "R9";

    function automatic bit allowed(int k, bit wr, int r);
        int mode  = (k == 3) ? 1 : 3;
        int level = (k == 1) ? 1 : (k == 2) ? 2 : 3;
        if (mode < 2 || level == 0) return 0;
        if (wr) return !((r == 0 || r == 1 || r == 3) && level <= 1);
        if (r == 0 || r == 1 || r == 4 || r == 5) return (level % 2) == 1;
        return 1;
    endfunction

    function automatic void step(int k);
        int idx = int'(m_reg[k][2] & 32'hFF);
        int r   = int'(acc_reg);
        e_rdv[k] = 0; e_rd[k] = 0; e_err[k] = 0; e_fl[k] = 0; e_lr[k] = 0;
        if (acc_valid) begin
            if (!allowed(k, acc_write, r)) begin
                e_err[k] = 1;
                e_rdv[k] = !acc_write;
            end else if (!acc_write) begin
                e_rdv[k] = 1;
                if (r == 4) e_rd[k] = m_lo[k][idx];
                else if (r == 5) begin
                    e_rd[k] = m_hi[k][idx];
                    m_reg[k][0] = {24'd0, m_tid[k][idx]};
                end else e_rd[k] = m_reg[k][r];
            end else begin
                if (r == 4) m_lo[k][idx] = acc_wdata;
                else if (r == 5) begin
                    m_hi[k][idx]  = acc_wdata;
                    m_tid[k][idx] = m_reg[k][0][7:0];
                end else if (r == 3) begin
                    m_reg[k][3] = acc_wdata & 32'hFFFF_FC00;
                    e_lr[k] = 1; e_lva[k] = m_reg[k][3]; e_lu[k] = user_mode;
                end else begin
                    if ((r == 0 || r == 1) && m_reg[k][r] != acc_wdata) e_fl[k] = 1;
                    m_reg[k][r] = acc_wdata;
                end
            end
        end
        if (lookup_done) m_reg[k][2] = lookup_hit ? {24'd0, lookup_entry} : 32'h8000_0000;
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < NDUT; k++) begin
            if (!rst_n) begin
                for (int j = 0; j < 8; j++) m_reg[k][j] = 0;
                e_rdv[k] = 0; e_rd[k] = 0; e_err[k] = 0; e_fl[k] = 0;
                e_lr[k] = 0; e_lva[k] = 0; e_lu[k] = 0;
            end else step(k);
        end
    end

    task automatic chk(int k, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s dut%0d %s act=%h exp=%h", phase, k, what, act, exp);
        end
    endtask

    initial begin
        for (int k = 0; k < NDUT; k++) begin
            e_rdv[k] = 0; e_rd[k] = 0; e_err[k] = 0; e_fl[k] = 0;
            e_lr[k] = 0; e_lva[k] = 0; e_lu[k] = 0;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            for (int k = 0; k < NDUT; k++) begin
                chk(k, "rd_valid", {31'd0, o_rdv[k]}, {31'd0, e_rdv[k]});
                chk(k, "rd_data", o_rd[k], e_rd[k]);
                chk(k, "err_strobe", {31'd0, o_err[k]}, {31'd0, e_err[k]});
                chk(k, "flush_pulse", {31'd0, o_fl[k]}, {31'd0, e_fl[k]});
                chk(k, "lookup_req", {31'd0, o_lr[k]}, {31'd0, e_lr[k]});
                chk(k, "lookup_vaddr", o_lva[k], e_lva[k]);
                chk(k, "lookup_user", {31'd0, o_lu[k]}, {31'd0, e_lu[k]});
            end
        end
    end

    task automatic acc(bit wr, int r, logic [31:0] d);
        @(negedge clk); #1;
        acc_valid = 1; acc_write = wr; acc_reg = 3'(r); acc_wdata = d; lookup_done = 0;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk); #1;
            acc_valid = 0; lookup_done = 0;
        end
    endtask

    task automatic answer(bit hit, logic [7:0] ent);
        @(negedge clk); #1;
        acc_valid = 0; lookup_done = 1; lookup_hit = hit; lookup_entry = ent;
    endtask

    initial begin
        phase = "R9";
        idle(3);
        rst_n = 1;
        for (int r = 0; r < 4; r++) acc(0, r, 0);
        idle(1);
        phase = "R5";
        acc(1, 2, 5);
        acc(1, 4, 32'h1111_2222);
        acc(1, 0, 32'h3C);
        acc(1, 5, 32'hAAAA_0000);
        acc(1, 2, 6);
        acc(1, 4, 32'h0000_0033);
        acc(1, 5, 32'h0000_0044);
        acc(1, 2, 5);
        acc(0, 4, 0);
        acc(0, 5, 0);
        idle(1);
        phase = "R6";
        acc(1, 0, 32'h77);
        acc(0, 5, 0);
        acc(0, 0, 0);
        idle(1);
        phase = "R7";
        acc(1, 1, 32'hF0F0_0000);
        acc(1, 1, 32'hF0F0_0000);
        acc(1, 0, 32'h3C);
        acc(1, 0, 32'h3D);
        idle(1);
        phase = "R8";
        user_mode = 1;
        acc(1, 3, 32'h1234_5FFF);
        user_mode = 0;
        acc(1, 3, 32'hFFFF_FFFF);
        acc(0, 3, 0);
        idle(1);
        phase = "R10";
        answer(1, 8'h2A);
        acc(0, 2, 0);
        answer(0, 8'h11);
        acc(0, 2, 0);
        idle(1);
        phase = "R2";
        acc(1, 2, 6);
        acc(0, 4, 0);
        acc(0, 5, 0);
        phase = "R3";
        acc(0, 0, 0);
        acc(0, 1, 0);
        phase = "R4";
        acc(1, 1, 32'h0000_000F);
        acc(1, 0, 32'h0000_0099);
        acc(1, 3, 32'h0000_4400);
        acc(1, 6, 32'hCAFE_F00D);
        acc(0, 6, 0);
        acc(0, 1, 0);
        phase = "R1";
        acc(1, 7, 32'h5555_AAAA);
        acc(0, 7, 0);
        acc(0, 2, 0);
        phase = "R11";
        acc(0, 4, 0);
        idle(2);
        acc(1, 0, 32'h1);
        idle(2);
        phase = "R9";
        @(negedge clk); #1; rst_n = 0;
        idle(2);
        @(negedge clk); #1; rst_n = 1;
        for (int r = 0; r < 8; r++) acc(0, r, 0);
        acc(1, 2, 5);
        acc(0, 4, 0);
        acc(0, 5, 0);
        idle(3);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog act=running exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule